// File: doc/BRIEF.md
# Event Capture Unit with Input Filter

This block stamps external events with the value of a free-running timer. Either an external capture pin or an analog comparator output drives it, chosen by a control bit. The chosen input is resynchronised to the system clock. It can then pass through a short digital filter before an edge detector looks for the programmed polarity. On a qualifying edge, the timer value present at the counter input is stored in a capture register, and a sticky flag is raised in the same clock cycle.

Software drives the block through a small write-strobe bus. Address 0 holds four control bits. A write to address 1 clears the flag. The flag raises an interrupt request when that is enabled. The interrupt controller clears the flag by pulsing an acknowledge line. The counter is an input only, so its prescaling happens elsewhere. The filter always runs on the undivided system clock.

Top module: `evt_capture_unit`

## Requirements
- R1: After reset the capture value is zero, the flag and interrupt request are low, and the control bits are all zero: pin source, falling edge, filter off, interrupt off.
- R2: With the filter off, an active input transition applied before clock edge E0 stores the counter value sampled at edge E2 and sets the flag at that same edge E2. The flag is still low after edge E1.
- R3: Control bit 1 picks the active edge: 1 for rising, 0 for falling. A transition in the other direction leaves the flag low.
- R4: Control bit 0 picks the source: 0 for the capture pin, 1 for the comparator output. Transitions on the unselected input never cause a capture.
- R5: Changing control bit 0 while the two inputs differ in level presents a transition to the edge detector. If that transition has the active polarity, it captures the counter like any other event.
- R6: Control bit 2 enables the filter. The filtered level changes only after four consecutive synchronised samples agree, so with the filter on, a pulse shorter than four cycles never captures and a pulse of four or more cycles does.
- R7: With the filter on, capture happens four cycles later than in R2: at edge E6, storing the counter value sampled there.
- R8: The interrupt request is high exactly when the flag is set and control bit 3 is one.
- R9: A one-cycle acknowledge pulse clears the flag at the next clock edge.
- R10: A write to address 1 with data bit 0 set clears the flag. A write there with data bit 0 clear has no effect.
- R11: When a clear and a capture fall on the same clock edge, the flag stays set.
- R12: A later event overwrites the capture value with the newer count, even if the earlier value was never read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_in | input | CW | Free-running timer count |
| cap_pin | input | 1 | External capture pin |
| cmp_out | input | 1 | Analog comparator output |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 for control, 1 for flag clear |
| bus_wdata | input | 4 | Write data: {irq_en, filt_en, edge_rise, src_cmp} at address 0, bit 0 clears at address 1 |
| intr_ack | input | 1 | Interrupt acknowledge pulse |
| cap_value | output | CW | Captured counter value |
| cap_flag | output | 1 | Capture flag |
| intr_req | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- a detected edge loads the counter and sets the flag at the next edge;
- the capture value holds steady between events;
- a clear without a capture drops the flag, and a capture beats a simultaneous clear;
- the interrupt request is never high without the flag;
- the filtered level changes only after a run of agreeing samples.

The exact latencies of two and six cycles, pulse rejection by width, polarity selection, the capture caused by switching the source, and the ignored inputs can only be shown by the bench's scenarios. In those scenarios, stored counts are compared with arithmetic on a bench-driven counter.

// File: rtl/evt_capture_unit.sv
module evt_capture_unit #(
  parameter int CW       = 16,
  parameter int FILT_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_in,
  input  logic          cap_pin,
  input  logic          cmp_out,
  input  logic          bus_we,
  input  logic          bus_addr,
  input  logic [3:0]    bus_wdata,
  input  logic          intr_ack,
  output logic [CW-1:0] cap_value,
  output logic          cap_flag,
  output logic          intr_req
);
  localparam int HL = FILT_LEN - 1;

  logic          src_cmp, edge_rise, filt_en, irq_en;
  logic [1:0]    sync;
  logic [HL-1:0] hist;
  logic          filt_q, lvl_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {irq_en, filt_en, edge_rise, src_cmp} <= '0;
    else if (bus_we && !bus_addr) {irq_en, filt_en, edge_rise, src_cmp} <= bus_wdata;

  wire raw = src_cmp ? cmp_out : cap_pin;
  wire smp = sync[1];

  wire all_hi = smp & (&hist);
  wire all_lo = ~smp & ~(|hist);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync   <= '0;
      hist   <= '0;
      filt_q <= 1'b0;
    end else begin
      sync <= {sync[0], raw};
      hist <= {hist[HL-2:0], smp};
      if (all_hi)      filt_q <= 1'b1;
      else if (all_lo) filt_q <= 1'b0;
    end

  wire level = filt_en ? filt_q : smp;
  wire hit   = edge_rise ? (level & ~lvl_d) : (~level & lvl_d);
  wire clr   = intr_ack | (bus_we & bus_addr & bus_wdata[0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_d     <= 1'b0;
      cap_value <= '0;
      cap_flag  <= 1'b0;
    end else begin
      lvl_d    <= level;
      cap_flag <= hit | (cap_flag & ~clr);
      if (hit) cap_value <= cnt_in;
    end

  assign intr_req = cap_flag & irq_en;

  assert_capture_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cap_flag && cap_value == $past(cnt_in)));

  assert_value_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cap_value));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !cap_flag);

  assert_capture_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && hit) |=> cap_flag);

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    intr_req |-> cap_flag);

  assert_filter_agree_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |->
      ($past(hist) == {HL{filt_q}} && $past(smp) == filt_q));
endmodule

// File: tb/evt_capture_unit_tb.sv
module evt_capture_unit_tb;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic          pin = 1'b0, cmp = 1'b0;
  logic          we = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [3:0]    wd = '0;
  logic [CW-1:0] cap_value;
  logic          cap_flag, intr_req;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 1'b1;

  evt_capture_unit #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt), .cap_pin(pin), .cmp_out(cmp),
    .bus_we(we), .bus_addr(addr), .bus_wdata(wd), .intr_ack(ack),
    .cap_value(cap_value), .cap_flag(cap_flag), .intr_req(intr_req));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [3:0] d);
    we = 1'b1; addr = a; wd = d;
    step(1);
    we = 1'b0; addr = 1'b0; wd = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Drive the pin and check that capture lands exactly lat+1 edges later.
  task automatic pin_event(input logic lvl, input int lat, input string req);
    logic [CW-1:0] v;
    pin = lvl; v = cnt;
    step(lat);
    chk(cap_flag == 1'b0, req, cap_flag, 0);
    step(1);
    chk(cap_flag == 1'b1, req, cap_flag, 1);
    chk(cap_value == CW'(v + lat), req, cap_value, CW'(v + lat));
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk(cap_flag == 1'b0, "R1", cap_flag, 0);
    chk(cap_value == '0, "R1", cap_value, 0);
    chk(intr_req == 1'b0, "R1", intr_req, 0);
    pin = 1'b1; step(10);
    chk(cap_flag == 1'b0, "R1", cap_flag, 0);

    // polarity x filter sweep: R2 R3 R7
    for (int f = 0; f < 2; f++)
      for (int p = 0; p < 2; p++) begin
        wr(1'b0, {1'b0, f[0], p[0], 1'b0});
        pin = p[0]; step(12);
        wr(1'b1, 4'b0001);
        pin = ~p[0]; step(12);
        chk(cap_flag == 1'b0, "R3", cap_flag, 0);
        pin_event(p[0], 2 + 4 * f, f ? "R7" : "R2");
      end

    // filter pulse-width sweep: R6
    wr(1'b0, 4'b0110);
    pin = 1'b0; step(12);
    wr(1'b1, 4'b0001);
    for (int w = 1; w <= 6; w++) begin
      logic [CW-1:0] v;
      pin = 1'b1; v = cnt;
      step(w);
      pin = 1'b0;
      step(12);
      chk(cap_flag == (w >= 4), "R6", cap_flag, (w >= 4));
      if (w >= 4) chk(cap_value == CW'(v + 6), "R6", cap_value, CW'(v + 6));
      wr(1'b1, 4'b0001);
    end

    // source switch and unselected input: R5 R4
    wr(1'b0, 4'b0010);
    pin = 1'b0; cmp = 1'b1; step(12);
    wr(1'b1, 4'b0001);
    chk(cap_flag == 1'b0, "R5", cap_flag, 0);
    begin
      logic [CW-1:0] v;
      wr(1'b0, 4'b0011);
      v = cnt;
      step(2);
      chk(cap_flag == 1'b0, "R5", cap_flag, 0);
      step(1);
      chk(cap_flag == 1'b1, "R5", cap_flag, 1);
      chk(cap_value == CW'(v + 2), "R5", cap_value, CW'(v + 2));
    end
    wr(1'b1, 4'b0001);
    pin = 1'b1; step(8); pin = 1'b0; step(8);
    chk(cap_flag == 1'b0, "R4", cap_flag, 0);
    cmp = 1'b0; step(8);
    begin
      logic [CW-1:0] v;
      cmp = 1'b1; v = cnt;
      step(3);
      chk(cap_flag == 1'b1, "R4", cap_flag, 1);
      chk(cap_value == CW'(v + 2), "R4", cap_value, CW'(v + 2));
    end

    // interrupt and acknowledge: R8 R9
    chk(intr_req == 1'b0, "R8", intr_req, 0);
    wr(1'b0, 4'b1011);
    chk(intr_req == 1'b1, "R8", intr_req, 1);
    ack = 1'b1; step(1); ack = 1'b0;
    chk(cap_flag == 1'b0, "R9", cap_flag, 0);
    chk(intr_req == 1'b0, "R8", intr_req, 0);

    // software clear: R10
    cmp = 1'b0; step(8); cmp = 1'b1; step(8);
    chk(cap_flag == 1'b1, "R10", cap_flag, 1);
    wr(1'b1, 4'b0000);
    chk(cap_flag == 1'b1, "R10", cap_flag, 1);
    wr(1'b1, 4'b0001);
    chk(cap_flag == 1'b0, "R10", cap_flag, 0);

    // overwrite and clear/capture collision: R12 R11
    begin
      logic [CW-1:0] v1, v2;
      cmp = 1'b0; step(8);
      cmp = 1'b1; v1 = cnt; step(8);
      chk(cap_value == CW'(v1 + 2), "R12", cap_value, CW'(v1 + 2));
      cmp = 1'b0; step(8);
      cmp = 1'b1; v2 = cnt;
      step(2);
      ack = 1'b1; step(1); ack = 1'b0;
      chk(cap_flag == 1'b1, "R11", cap_flag, 1);
      chk(cap_value == CW'(v2 + 2), "R12", cap_value, CW'(v2 + 2));
    end

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule